// File: doc/BRIEF.md
# Power-Down Retention Mode Unlock Detector

This block sits on the device side of an asynchronous SRAM-style memory port. It watches the bus cycles that the port has finished and looks for one exact six-cycle sequence. The sequence is a read of the all-ones address, then four writes to that same address, then a read whose address carries a mode key. When the sequence is complete, the block selects how much of the array keeps its contents while the device is powered down.

The block tracks the level of the active-high chip enable. It reports the low-power state. For any query address it also tells a memory model whether that word survives power-down. A bus cycle that breaks the sequence cancels the detection, and the cycle itself is left to act as a normal access. A key that matches no known encoding leaves the mode unchanged and raises an error pulse.

FSM states: `ST_IDLE` (no progress), `ST_RD1` (first read seen), `ST_WR1`..`ST_WR4` (that many top-address writes seen), `ST_COMMIT` (key captured, waiting for standby). Transitions: a top read from any state except `ST_WR4`/`ST_COMMIT` goes to `ST_RD1`. A top write advances `ST_RD1`→`ST_WR1`→`ST_WR2`→`ST_WR3`→`ST_WR4`. Any read in `ST_WR4` goes to `ST_COMMIT`. `ST_COMMIT` goes to `ST_IDLE` on a standby cycle. Any other event, or a low chip enable, goes to `ST_IDLE`.

Top module: `pdm_seq_detect`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (no retention), `lowpwr_o` is 0 and `key_err_o` is 0.
- R2: After the read, the four top-address writes and a key read at 17FFFFh, `mode_o` becomes 2'b01. In this mode words 000000h..03FFFFh are kept.
- R3: A key read at 0FFFFFh selects 2'b10, where words 000000h..07FFFFh are kept. A key read at 1FFFFFh selects 2'b00, where nothing is kept. The key is valid only when address bits 18..0 are all ones. Bits 20..19 are then 11, 10 or 01.
- R4: `mode_o` only ever takes the values 2'b00, 2'b01 and 2'b10.
- R5: A write to any address other than 1FFFFFh while 0..3 top writes have been seen cancels the sequence. A write seen in place of the key read also cancels it. A later key read then leaves `mode_o` unchanged.
- R6: An out-of-order read to any address other than 1FFFFFh cancels progress. An out-of-order read to 1FFFFFh counts as a new first read.
- R7: A key read whose address fails the R3 format (for example 07FFFFh or 100000h) leaves `mode_o` unchanged. `key_err_o` is then high for exactly one cycle.
- R8: `mode_o` and `key_err_o` update on the first clock edge with `bus_idle` high after the key read. `mode_o` never changes on an edge where `bus_idle` was low.
- R9: `retain_o` is 1 only when `chk_addr` lies in the range kept by the current `mode_o`. In mode 2'b00 it is always 0.
- R10: When `ce2` is low and `bus_idle` is high at a clock edge, `lowpwr_o` is 1 after that edge. While `bus_idle` is low, `lowpwr_o` does not rise.
- R11: `lowpwr_o` stays 1 while `ce2` is low. It returns to 0 after the first edge with `ce2` high.
- R12: Bus events while `ce2` is low are ignored, and a low `ce2` cancels any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | One-cycle strobe: a bus cycle has completed |
| cyc_write | input | 1 | 1 = the completed cycle was a write, 0 = a read |
| cyc_addr | input | 21 | Word address of the completed cycle |
| bus_idle | input | 1 | 1 = port is in standby (first chip enable inactive) |
| ce2 | input | 1 | Level of the active-high chip enable |
| chk_addr | input | 21 | Query address for the retain flag |
| mode_o | output | 2 | Retention mode: 00 none, 01 lower 256 K words, 10 lower 512 K words |
| lowpwr_o | output | 1 | Device is in power-down |
| retain_o | output | 1 | `chk_addr` survives power-down in the current mode |
| key_err_o | output | 1 | One-cycle pulse: the sequence completed with an unknown key |

## Verification
A wrong sequence state shows up only when a sequence completes. A state that is too lenient changes `mode_o` after a cancelled sequence. A state that is too strict leaves `mode_o` unchanged after a valid one. Either fault is visible one standby edge after the key read, and `retain_o` shows it at once for addresses near 040000h and 080000h. The random stimulus mixes many near-miss sequences with full ones so that stray progress is exposed quickly. Errors in the power tracking show on `lowpwr_o` one edge after `ce2` or `bus_idle` changes.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    typedef enum logic [1:0] {
        RET_NONE    = 2'b00,
        RET_EIGHTH  = 2'b01,
        RET_QUARTER = 2'b10
    } ret_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD1    = 3'd1,
        ST_WR1    = 3'd2,
        ST_WR2    = 3'd3,
        ST_WR3    = 3'd4,
        ST_WR4    = 3'd5,
        ST_COMMIT = 3'd6
    } seq_state_e;
endpackage

// File: rtl/pdm_key_decode.sv
module pdm_key_decode
    import pdm_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic [AW-1:0] addr,
    output logic          key_ok,
    output ret_mode_e     key_mode
);
    localparam int LOWW = AW - 2;

    logic low_ones;
    assign low_ones = &addr[LOWW-1:0];

    always_comb begin
        key_ok   = 1'b0;
        key_mode = RET_NONE;
        unique case (addr[AW-1:AW-2])
            2'b11: begin key_ok = low_ones; key_mode = RET_NONE;    end
            2'b10: begin key_ok = low_ones; key_mode = RET_EIGHTH;  end
            2'b01: begin key_ok = low_ones; key_mode = RET_QUARTER; end
            default: begin key_ok = 1'b0; key_mode = RET_NONE; end
        endcase
    end
endmodule

// File: rtl/pdm_retain.sv
module pdm_retain
    import pdm_pkg::*;
#(
    parameter int AW = 21
) (
    input  ret_mode_e     mode,
    input  logic [AW-1:0] addr,
    output logic          retain
);
    localparam int NPART = 2;
    logic [NPART-1:0] in_range;

    // Partial mode k keeps the lowest 2^(AW-3+k) words.
    for (genvar k = 0; k < NPART; k++) begin : g_part
        localparam int TOPB = 3 - k;
        assign in_range[k] = (addr[AW-1:AW-TOPB] == '0);
    end

    always_comb begin
        unique case (mode)
            RET_EIGHTH:  retain = in_range[0];
            RET_QUARTER: retain = in_range[1];
            default:     retain = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdm_power.sv
module pdm_power (
    input  logic clk,
    input  logic rst_n,
    input  logic ce2,
    input  logic bus_idle,
    output logic lowpwr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowpwr <= 1'b0;
        end else if (lowpwr) begin
            lowpwr <= !ce2;
        end else begin
            lowpwr <= !ce2 && bus_idle;
        end
    end
endmodule

// File: rtl/pdm_seq_detect.sv
module pdm_seq_detect
    import pdm_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_valid,
    input  logic          cyc_write,
    input  logic [AW-1:0] cyc_addr,
    input  logic          bus_idle,
    input  logic          ce2,
    input  logic [AW-1:0] chk_addr,
    output logic [1:0]    mode_o,
    output logic          lowpwr_o,
    output logic          retain_o,
    output logic          key_err_o
);
    localparam logic [AW-1:0] TOP_ADDR = '1;

    seq_state_e st, st_nxt;
    ret_mode_e  mode_q, pend_mode, dec_mode;
    logic       pend_ok, dec_ok;
    logic       ev, is_top, key_take;

    assign ev       = cyc_valid && ce2;
    assign is_top   = (cyc_addr == TOP_ADDR);
    assign key_take = ev && !cyc_write && (st == ST_WR4);

    pdm_key_decode #(.AW(AW)) u_key (
        .addr(cyc_addr), .key_ok(dec_ok), .key_mode(dec_mode)
    );

    always_comb begin
        st_nxt = st;
        if (!ce2) begin
            st_nxt = ST_IDLE;
        end else if (st == ST_COMMIT) begin
            if (bus_idle) st_nxt = ST_IDLE;
        end else if (ev && !cyc_write) begin
            if (st == ST_WR4) st_nxt = ST_COMMIT;
            else              st_nxt = is_top ? ST_RD1 : ST_IDLE;
        end else if (ev) begin
            unique case (st)
                ST_RD1:  st_nxt = is_top ? ST_WR1 : ST_IDLE;
                ST_WR1:  st_nxt = is_top ? ST_WR2 : ST_IDLE;
                ST_WR2:  st_nxt = is_top ? ST_WR3 : ST_IDLE;
                ST_WR3:  st_nxt = is_top ? ST_WR4 : ST_IDLE;
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register with captured key.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pend_ok   <= 1'b0;
            pend_mode <= RET_NONE;
        end else begin
            st <= st_nxt;
            if (key_take) begin
                pend_ok   <= dec_ok;
                pend_mode <= dec_mode;
            end
        end
    end

    // Outputs: commit on the standby cycle after the key read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= RET_NONE;
            key_err_o <= 1'b0;
        end else if (st == ST_COMMIT && bus_idle && ce2) begin
            if (pend_ok) mode_q <= pend_mode;
            key_err_o <= !pend_ok;
        end else begin
            key_err_o <= 1'b0;
        end
    end

    assign mode_o = mode_q;

    pdm_power u_pwr (
        .clk(clk), .rst_n(rst_n), .ce2(ce2), .bus_idle(bus_idle), .lowpwr(lowpwr_o)
    );

    pdm_retain #(.AW(AW)) u_ret (
        .mode(mode_q), .addr(chk_addr), .retain(retain_o)
    );
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce2,
    input logic       bus_idle,
    input logic [1:0] mode_o,
    input logic       lowpwr_o,
    input logic       retain_o,
    input logic       key_err_o
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11); // R4
    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        key_err_o |-> $stable(mode_o)); // R7
    AST_MODE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(bus_idle)); // R8
    AST_NONE_NO_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> !retain_o); // R9
    AST_LP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!lowpwr_o && !ce2 && bus_idle) |=> lowpwr_o); // R10
    AST_LP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lowpwr_o) |-> $past(bus_idle)); // R10
    AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_o && !ce2) |=> lowpwr_o); // R11
    AST_LP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_o && ce2) |=> !lowpwr_o); // R11
endmodule

bind pdm_seq_detect pdm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ce2(ce2), .bus_idle(bus_idle),
    .mode_o(mode_o), .lowpwr_o(lowpwr_o), .retain_o(retain_o), .key_err_o(key_err_o)
);

// File: tb/tb_pdm_seq_detect.sv
module tb_pdm_seq_detect;
    localparam int AW = 21;
    localparam logic [AW-1:0] TOP = 21'h1FFFFF;

    logic clk = 0;
    logic rst_n = 0;
    logic cyc_valid = 0, cyc_write = 0, bus_idle = 1, ce2 = 1;
    logic [AW-1:0] cyc_addr = '0, chk_addr = '0;
    logic [1:0] mode_o;
    logic lowpwr_o, retain_o, key_err_o;

    int checks = 0, errors = 0;
    int m_st = 0;
    logic [1:0] m_mode = 2'b00;
    logic m_err = 0;

    always #5 clk = ~clk;

    pdm_seq_detect #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .bus_idle(bus_idle), .ce2(ce2), .chk_addr(chk_addr),
        .mode_o(mode_o), .lowpwr_o(lowpwr_o), .retain_o(retain_o), .key_err_o(key_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_retain(input logic [1:0] m, input logic [AW-1:0] a);
        if (m == 2'b01) return a < 21'h040000;
        if (m == 2'b10) return a < 21'h080000;
        return 1'b0;
    endfunction

    // Reference sequence model per R2..R7.
    function automatic void model_step(input logic wr, input logic [AW-1:0] a);
        m_err = 0;
        if (!wr) begin
            if (m_st == 5) begin
                if (a[18:0] == '1 && a[20:19] != 2'b00) begin
                    m_mode = (a[20:19] == 2'b11) ? 2'b00 : (a[20:19] == 2'b10 ? 2'b01 : 2'b10);
                end else begin
                    m_err = 1;
                end
                m_st = 0;
            end else begin
                m_st = (a == TOP) ? 1 : 0;
            end
        end else begin
            m_st = (m_st >= 1 && m_st <= 4 && a == TOP) ? m_st + 1 : 0;
        end
    endfunction

    // One bus event, then one standby cycle. Returns at a falling edge.
    task automatic bus(input logic wr, input logic [AW-1:0] a);
        @(negedge clk);
        cyc_valid = 1; cyc_write = wr; cyc_addr = a; bus_idle = 0;
        @(negedge clk);
        cyc_valid = 0; bus_idle = 1;
        @(negedge clk);
        if (ce2) model_step(wr, a);
    endtask

    task automatic check_outs(input string req);
        check({req, " mode"}, mode_o, m_mode);
        check({req, " key_err"}, key_err_o, m_err);
    endtask

    task automatic full_seq(input logic [AW-1:0] key);
        bus(0, TOP);
        for (int i = 0; i < 4; i++) bus(1, TOP);
        bus(0, key);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 mode", mode_o, 2'b00);
        check("R1 lowpwr", lowpwr_o, 0);
        check("R1 key_err", key_err_o, 0);
        rst_n = 1;

        // R2: eighth retention, with retain boundaries (R9)
        full_seq(21'h17FFFF); check_outs("R2");
        chk_addr = 21'h03FFFF; #1 check("R9 eighth in", retain_o, 1);
        chk_addr = 21'h040000; #1 check("R9 eighth out", retain_o, 0);

        // R3: quarter, then none
        full_seq(21'h0FFFFF); check_outs("R3 quarter");
        chk_addr = 21'h07FFFF; #1 check("R9 quarter in", retain_o, 1);
        chk_addr = 21'h080000; #1 check("R9 quarter out", retain_o, 0);
        full_seq(21'h1FFFFF); check_outs("R3 none");
        chk_addr = 21'h000000; #1 check("R9 none", retain_o, 0);

        // R7: bad keys
        full_seq(21'h07FFFF); check_outs("R7 top bits 00");
        full_seq(21'h100000); check_outs("R7 low bits");
        @(negedge clk); check("R7 pulse one cycle", key_err_o, 0);

        // R5: cancel at write 2, and write in place of key
        bus(0, TOP); bus(1, TOP); bus(1, 21'h000123);
        bus(1, TOP); bus(1, TOP); bus(0, 21'h17FFFF); check_outs("R5 cancel wr2");
        bus(0, TOP); for (int i = 0; i < 4; i++) bus(1, TOP);
        bus(1, TOP); bus(0, 21'h17FFFF); check_outs("R5 fifth write");

        // R6: out-of-order reads
        bus(0, TOP); bus(1, TOP); bus(1, TOP); bus(0, 21'h000010);
        bus(1, TOP); bus(1, TOP); bus(0, 21'h17FFFF); check_outs("R6 restart");
        bus(0, TOP); bus(1, TOP); bus(0, TOP);
        for (int i = 0; i < 4; i++) bus(1, TOP);
        bus(0, 21'h0FFFFF); check_outs("R6 fresh first read");

        // R8: no commit while the bus stays busy after the key read
        bus(0, TOP); for (int i = 0; i < 4; i++) bus(1, TOP);
        @(negedge clk); cyc_valid = 1; cyc_write = 0; cyc_addr = 21'h17FFFF; bus_idle = 0;
        @(negedge clk); cyc_valid = 0;
        @(negedge clk); check("R8 held busy", mode_o, 2'b10);
        bus_idle = 1;
        @(negedge clk); check("R8 commit on idle", mode_o, 2'b01);
        m_mode = 2'b01; m_st = 0;

        // R10/R11: power-down
        ce2 = 0; bus_idle = 0;
        @(negedge clk); check("R10 no entry busy", lowpwr_o, 0);
        bus_idle = 1;
        @(negedge clk); check("R10 entry", lowpwr_o, 1);
        repeat (3) @(negedge clk);
        check("R11 hold", lowpwr_o, 1);
        // R12: events ignored while ce2 low
        full_seq(21'h0FFFFF); check_outs("R12 ignored");
        ce2 = 1;
        @(negedge clk); check("R11 exit", lowpwr_o, 0);
        // R12: low ce2 cancels progress
        bus(0, TOP); bus(1, TOP); bus(1, TOP);
        ce2 = 0; @(negedge clk); ce2 = 1; @(negedge clk); m_st = 0;
        bus(1, TOP); bus(1, TOP); bus(0, 21'h0FFFFF); check_outs("R12 cancel");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            logic [AW-1:0] a;
            if (r < 2) begin
                int k = $urandom_range(0, 4);
                a = (k == 0) ? 21'h17FFFF : (k == 1) ? 21'h0FFFFF : (k == 2) ? TOP :
                    (k == 3) ? 21'h07FFFF : 21'($urandom);
                full_seq(a); check_outs("R2 R3 R7 random seq");
            end else begin
                a = (r < 7) ? TOP : 21'($urandom);
                bus(logic'($urandom_range(0, 2) != 0), a);
                check_outs("R5 R6 random");
            end
            chk_addr = 21'($urandom) >> $urandom_range(0, 4);
            #1 check("R9 random", retain_o, exp_retain(m_mode, chk_addr));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule